// File: doc/BRIEF.md
# Ramp-Compare Conversion Width Timer

This block is the digital back end of a single-slope analog-to-digital converter. It runs on a fast timer clock and takes two asynchronous inputs. The first is a conversion frame signal, generated outside the block, with a short low phase and a long high phase; it repeats at roughly 1.2 kHz. The second is the output of an analog comparator that watches a falling integrator ramp. The comparator is low when a frame opens and goes high once the ramp passes below the sampled voltage. The conversion result is the number of timer clocks from the opening of the frame to that comparator rise.

Each frame produces one result, with a one-clock valid strobe. A frame in which the comparator never rises gives an all-ones result with a no-crossing flag. A frame in which the comparator is already high at the start gives a zero result with an early-crossing flag. If the high phase of the frame runs longer than a programmable limit, a frame fault flag is raised and the counter saturates at the limit. At the default 25.175 MHz timer clock a full frame is about 21000 counts, so counts and results are 15 bits wide.

Top module: `slope_conv_timer`

## Requirements
- R1: Both `conv_sync` and `cmp_async` pass through two flip-flop stages before edge detection. The valid strobe rises 3 clocks after the input change that completes a conversion: a comparator rise, a frame fall, or a frame rise for an early crossing.
- R2: `result` equals the number of clocks between the synchronized rise of `conv_sync` and the first synchronized rise of `cmp_async` in that frame. Inputs changed on the same clock therefore give 0, and inputs changed d clocks apart give d.
- R3: `result_valid` is high for exactly one clock per frame. Comparator toggles after the first rise in a frame produce no further strobe, and they leave `result` unchanged.
- R4: If `conv_sync` falls before any comparator rise, `result` becomes all ones (32767), `no_cross` is 1 and `early_cross` is 0.
- R5: If the synchronized comparator is already high when the frame opens, `result` is 0, `early_cross` is 1 and `no_cross` is 0.
- R6: The counter stops at `win_limit` and does not wrap. A comparator rise after that point reports exactly `win_limit`. `win_limit` is held stable while a frame is high.
- R7: `sync_fault` goes to 1 once the counter reaches `win_limit` while the frame is still high. This happens exactly when the high phase lasts more than `win_limit` clocks. The flag stays at 1 through the low phase and clears one clock after the next frame rise.
- R8: If a comparator rise and a frame fall are seen in the same synchronized cycle, the frame closes as a no-crossing result (all ones, `no_cross` = 1).
- R9: Synchronous active-high `rst` clears `result`, `result_valid`, `no_cross`, `early_cross` and `sync_fault` to 0.
- R10: `result`, `no_cross` and `early_cross` change only on a clock in which `result_valid` is high, and they hold until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_sync | input | 1 | Asynchronous conversion frame; counting runs while high |
| cmp_async | input | 1 | Asynchronous comparator output |
| win_limit | input | 15 | Maximum count for a frame high phase (nominally 21000) |
| result | output | 15 | Latched conversion count |
| result_valid | output | 1 | One-clock strobe marking a new result |
| no_cross | output | 1 | Result came from a frame with no comparator rise |
| early_cross | output | 1 | Comparator was high when the frame opened |
| sync_fault | output | 1 | Frame high phase exceeded `win_limit` |

## Verification
Two events can reach the capture logic in the same clock: a first comparator rise and the closing of the frame. The bench forces this by driving the comparator high on the same clock edge on which it drops the frame, so both pass through matching synchronizers and arrive together. It then expects a single strobe carrying all ones and the no-crossing flag, not a captured count. Random frames where the comparator delay lands on, just before, or just after the frame length exercise the same boundary from both sides. The bench also checks the exact strobe cycle in each case.

// File: rtl/sct_pkg.sv
package sct_pkg;
    localparam int CNT_W         = 15;
    localparam int DEFAULT_LIMIT = 21000;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        CAP_IDLE  = 1'b0,
        CAP_ARMED = 1'b1
    } cap_state_e;

    typedef struct packed {
        cnt_t value;
        logic no_cross;
        logic early;
    } conv_res_t;

    localparam cnt_t CNT_ONES = '1;

    function automatic cnt_t sat_step(input cnt_t cur, input cnt_t lim);
        return (cur >= lim) ? cur : cnt_t'(cur + 1'b1);
    endfunction
endpackage

// File: rtl/sct_sync.sv
module sct_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] lvl_d
);
    // STAGES synchronizing flops plus one extra flop for edge detection
    for (genvar s = 0; s <= STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= g_stage[s-1].q;
            end
        end
    end

    assign lvl   = g_stage[STAGES-1].q;
    assign lvl_d = g_stage[STAGES].q;
endmodule

// File: rtl/sct_window.sv
module sct_window
    import sct_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync_lvl,
    input  logic sync_rise,
    input  cnt_t limit,
    output cnt_t count,
    output logic fault
);
    // Counter is cleared while the frame is low and saturates at the limit
    always_ff @(posedge clk) begin
        if (rst || !sync_lvl) count <= '0;
        else                  count <= sat_step(count, limit);
    end

    // Fault is raised when the limit is hit inside a high phase and cleared at the next frame rise
    always_ff @(posedge clk) begin
        if (rst)                              fault <= 1'b0;
        else if (sync_rise)                   fault <= 1'b0;
        else if (sync_lvl && count >= limit)  fault <= 1'b1;
    end
endmodule

// File: rtl/sct_capture.sv
module sct_capture
    import sct_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_lvl,
    input  logic      sync_rise,
    input  logic      cmp_lvl,
    input  logic      cmp_rise,
    input  cnt_t      count,
    output conv_res_t res,
    output logic      valid
);
    cap_state_e state_q, state_d;
    conv_res_t  res_d;
    logic       valid_d;

    always_comb begin
        state_d = state_q;
        res_d   = res;
        valid_d = 1'b0;
        if (sync_rise) begin
            if (cmp_lvl) begin
                res_d   = '{value: '0, no_cross: 1'b0, early: 1'b1};
                valid_d = 1'b1;
                state_d = CAP_IDLE;
            end else begin
                state_d = CAP_ARMED;
            end
        end else if (state_q == CAP_ARMED) begin
            // A frame close takes precedence over a comparator rise seen in the same cycle
            if (!sync_lvl) begin
                res_d   = '{value: CNT_ONES, no_cross: 1'b1, early: 1'b0};
                valid_d = 1'b1;
                state_d = CAP_IDLE;
            end else if (cmp_rise) begin
                res_d   = '{value: count, no_cross: 1'b0, early: 1'b0};
                valid_d = 1'b1;
                state_d = CAP_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CAP_IDLE;
            res     <= '0;
            valid   <= 1'b0;
        end else begin
            state_q <= state_d;
            res     <= res_d;
            valid   <= valid_d;
        end
    end
endmodule

// File: rtl/slope_conv_timer.sv
module slope_conv_timer
    import sct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_sync,
    input  logic             cmp_async,
    input  logic [CNT_W-1:0] win_limit,
    output logic [CNT_W-1:0] result,
    output logic             result_valid,
    output logic             no_cross,
    output logic             early_cross,
    output logic             sync_fault
);
    localparam int N_IN    = 2;
    localparam int IDX_SYN = 0;
    localparam int IDX_CMP = 1;

    logic [N_IN-1:0] in_lvl, in_lvl_d;
    logic            sync_rise, cmp_rise;
    cnt_t            count;
    conv_res_t       res;

    sct_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   ({cmp_async, conv_sync}),
        .lvl   (in_lvl),
        .lvl_d (in_lvl_d)
    );

    assign sync_rise = in_lvl[IDX_SYN] & ~in_lvl_d[IDX_SYN];
    assign cmp_rise  = in_lvl[IDX_CMP] & ~in_lvl_d[IDX_CMP];

    sct_window u_window (
        .clk       (clk),
        .rst       (rst),
        .sync_lvl  (in_lvl[IDX_SYN]),
        .sync_rise (sync_rise),
        .limit     (win_limit),
        .count     (count),
        .fault     (sync_fault)
    );

    sct_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .sync_lvl  (in_lvl[IDX_SYN]),
        .sync_rise (sync_rise),
        .cmp_lvl   (in_lvl[IDX_CMP]),
        .cmp_rise  (cmp_rise),
        .count     (count),
        .res       (res),
        .valid     (result_valid)
    );

    assign result      = res.value;
    assign no_cross    = res.no_cross;
    assign early_cross = res.early;
endmodule

// File: rtl/slope_conv_timer_chk.sv
module slope_conv_timer_chk
    import sct_pkg::*;
(
    input logic clk,
    input logic rst,
    input cnt_t win_limit,
    input cnt_t result,
    input logic result_valid,
    input logic no_cross,
    input logic early_cross
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid); // R3

    AST_NOCROSS_ONES: assert property (@(posedge clk) disable iff (rst)
        (result_valid && no_cross) |-> (result == CNT_ONES && !early_cross)); // R4

    AST_EARLY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (result_valid && early_cross) |-> (result == '0 && !no_cross)); // R5

    AST_RESULT_CAPPED: assert property (@(posedge clk) disable iff (rst)
        (result_valid && !no_cross) |-> (result <= win_limit)); // R6

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> ($stable(result) && $stable(no_cross) && $stable(early_cross))); // R10
endmodule

bind slope_conv_timer slope_conv_timer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .win_limit    (win_limit),
    .result       (result),
    .result_valid (result_valid),
    .no_cross     (no_cross),
    .early_cross  (early_cross)
);

// File: tb/slope_conv_timer_tb_top.sv
module slope_conv_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ONES       = 32767;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_sync = 1'b0;
    logic        cmp_async = 1'b0;
    logic [14:0] win_limit = 15'd21000;
    logic [14:0] result;
    logic        result_valid, no_cross, early_cross, sync_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slope_conv_timer dut_i (
        .clk          (clk),
        .rst          (rst),
        .conv_sync    (conv_sync),
        .cmp_async    (cmp_async),
        .win_limit    (win_limit),
        .result       (result),
        .result_valid (result_valid),
        .no_cross     (no_cross),
        .early_cross  (early_cross),
        .sync_fault   (sync_fault)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Expected result for a frame of high length h, comparator delay d, limit l
    function automatic int exp_value(input int l, input int h, input int d);
        if (d == 0) return 0;
        if (d >= h) return ONES;
        return (d < l) ? d : l;
    endfunction

    function automatic int exp_strobe_idx(input int h, input int d);
        return ((d < h) ? d : h) + 3;
    endfunction

    // One frame: sync rises at index 0, comparator rises at index d, sync falls at index h
    task automatic run_conv(input int l, input int h, input int d, input int low_len);
        int n_valid = 0, v_idx = -1, v_res = 0, v_nc = 0, v_ec = 0;
        int ev  = exp_value(l, h, d);
        int enc = (d > 0 && d >= h) ? 1 : 0;
        int eec = (d == 0) ? 1 : 0;
        @(negedge clk);
        win_limit = 15'(l);
        for (int idx = 0; idx <= h + low_len; idx++) begin
            @(negedge clk);
            if (result_valid) begin
                n_valid++;
                if (v_idx < 0) begin
                    v_idx = idx; v_res = int'(result); v_nc = int'(no_cross); v_ec = int'(early_cross);
                end
            end
            if (idx == 4)
                check(sync_fault == 1'b0, "R7 fault cleared after frame rise", int'(sync_fault), 0);
            if (idx == h + 5)
                check(sync_fault == (h > l), "R7 fault level in low phase", int'(sync_fault), (h > l) ? 1 : 0);
            if (idx == 0) begin conv_sync = 1'b1; cmp_async = (d == 0); end
            if (idx == d && d > 0) cmp_async = 1'b1;
            if (d > 0 && d + 4 < h) begin
                if (idx == d + 2) cmp_async = 1'b0;
                if (idx == d + 4) cmp_async = 1'b1;
            end
            if (idx == h) conv_sync = 1'b0;
            if (idx == h + 1) cmp_async = 1'b0;
        end
        check(n_valid == 1, "R3 single strobe per frame", n_valid, 1);
        check(v_idx == exp_strobe_idx(h, d), "R1 strobe latency", v_idx, exp_strobe_idx(h, d));
        if (d == 0)      check(v_res == ev && v_ec == 1 && v_nc == 0, "R5 early crossing", v_res, ev);
        else if (d == h) check(v_res == ev && v_nc == 1, "R8 collision is no-crossing", v_res, ev);
        else if (d > h)  check(v_res == ev && v_nc == 1 && v_ec == 0, "R4 no crossing", v_res, ev);
        else if (d > l)  check(v_res == ev, "R6 saturated count", v_res, ev);
        else             check(v_res == ev && v_nc == 0 && v_ec == 0, "R2 crossing count", v_res, ev);
        check(v_nc == enc && v_ec == eec, "R10 flags with strobe", v_nc * 2 + v_ec, enc * 2 + eec);
        check(int'(result) == ev && int'(no_cross) == enc, "R10 result held after strobe", int'(result), ev);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(result == 0 && !result_valid && !no_cross && !early_cross && !sync_fault,
              "R9 reset state", int'(result), 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);

        // Directed corners
        run_conv(40, 60, 17, 8);
        run_conv(40, 60, 1, 8);
        run_conv(40, 60, 0, 8);
        run_conv(40, 60, 60, 8);   // collision of comparator rise and frame fall
        run_conv(40, 60, 59, 8);
        run_conv(40, 30, 45, 8);
        run_conv(40, 80, 40, 8);
        run_conv(40, 80, 55, 8);
        run_conv(40, 41, 10, 8);
        run_conv(40, 40, 10, 8);

        // Reset after a saturating frame clears everything
        run_conv(25, 70, 50, 8);
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check(result == 0 && !result_valid && !no_cross && !early_cross && !sync_fault,
              "R9 reset clears after frame", int'(result), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // Constrained random frames
        for (int k = 0; k < 60; k++) begin
            int l = 20 + int'($urandom_range(100));
            int h = 8 + int'($urandom_range(140));
            int sel = int'($urandom_range(9));
            int d;
            if (sel == 0)      d = 0;
            else if (sel == 1) d = h;
            else if (sel == 2) d = h + 1 + int'($urandom_range(10));
            else if (sel == 3) d = h - 1;
            else               d = 1 + int'($urandom_range(h - 1));
            run_conv(l, h, d, 6 + int'($urandom_range(6)));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule